// File: doc/BRIEF.md
# Destructive-Read Memory Cycle Controller

This block fronts a small register-file array that behaves like magnetic core storage: sensing a word wipes it, so every access is a short sequence of clear, read and write phases chosen by a mode select. The caller presents an address, write data and a two-bit mode. It then raises one of two initiation inputs, read-init or write-init. The controller runs the matching phase sequence, returns the sensed word with a one-clock valid strobe, and lowers its busy output when the location has its final value.

Two mode variants are full cycles: clear-then-write, and read-then-restore. A third variant, read/modify/write, is split in two. It senses and clears the word, then holds busy high and waits for a fresh rising edge of write-init before it stores the write data. A read-only variant senses the word and leaves the location at zero. Two qualifier inputs can narrow these choices. One forces full-cycle behaviour. The other turns off the read-only variant. Cycles are re-armed by level: an init input has to drop before it can start another cycle.

Top module: `core_cycle_ctrl`

## Requirements
- R1: After reset, busy, rdValid and rdData are all zero and every word of the array reads back as zero.
- R2: While idle, a rising edge on rdInit or wrInit starts a cycle and captures addr, wrData and the mode. busy is high from the next clock until the cycle finishes.
- R3: Mode 2'b00 (clear/write) leaves wrData in the addressed word and never pulses rdValid.
- R4: Mode 2'b01 (read/restore) pulses rdValid for exactly one clock with the stored word on rdData, and the word keeps its value afterwards.
- R5: Mode 2'b11 (read-only) returns the stored word on rdData with a rdValid pulse, and the word holds zero afterwards.
- R6: Mode 2'b10 (read/modify/write) returns the stored word, then keeps busy high for as long as needed until a rising edge of wrInit. It then stores the wrData present at that edge.
- R7: A rising edge of either init input during a cycle is ignored. The single exception is wrInit during the read/modify/write pause. The address and data of the cycle stay as captured.
- R8: With fullCycSel high, mode 2'b10 runs as read/restore: it does not pause, and the word is unchanged.
- R9: With rdOnlyEn low, mode 2'b11 runs as read/restore, and the word is unchanged.
- R10: An init input held high after its cycle ends does not start another cycle. It must go low and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdInit | input | 1 | Read-side cycle initiation, acts on its rising edge |
| wrInit | input | 1 | Write-side initiation, also resumes a paused split cycle |
| modeSel | input | 2 | 00 clear/write, 01 read/restore, 10 read/modify/write, 11 read-only |
| fullCycSel | input | 1 | High forces full-cycle behaviour, so read/modify/write becomes read/restore |
| rdOnlyEn | input | 1 | Low turns off read-only, so that mode becomes read/restore |
| addr | input | AW (4) | Word address, captured at cycle start |
| wrData | input | DW (8) | Write data, captured at cycle start or at the resuming wrInit edge |
| rdData | output | DW (8) | Word sensed by the last read phase |
| rdValid | output | 1 | One-clock strobe when rdData is fresh |
| busy | output | 1 | High while a cycle, including a split-cycle pause, is in progress |

## Verification
The bench looks for a restore phase that is missing or misplaced. If the read phase cleared the word but nothing wrote it back, a second read/restore of the same word would return zero instead of the original value. The read-only case checks the opposite direction: a design that restored the word in this mode would show the old value on the next read, where zero is expected. In the split cycle, the bench holds the pause for many clocks and raises a stray rdInit during it. A controller that timed out of the pause, or took the stray edge as a new start, would end busy early or return a second read strobe. The bench also holds an init input high after its cycle ends. A design that starts cycles on the level rather than the edge would keep busy asserted.

// File: rtl/core_cycle_pkg.sv
package core_cycle_pkg;

  typedef enum logic [1:0] {
    MODE_CLR_WR  = 2'b00,
    MODE_RD_RST  = 2'b01,
    MODE_RD_MOD  = 2'b10,
    MODE_RD_ONLY = 2'b11
  } cycMode_t;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_CLR     = 3'd1,
    PH_READ    = 3'd2,
    PH_WRITE   = 3'd3,
    PH_RESTORE = 3'd4,
    PH_PAUSE   = 3'd5
  } phase_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic latchCyc;  // capture address and write data
    logic latchWr;   // capture write data only (split-cycle resume)
    logic clrWord;   // zero the addressed word
    logic rdWord;    // sense (and destroy) the addressed word
    logic wrWord;    // store captured write data
    logic rstWord;   // store sensed data back
  } dpCtl_t;

endpackage

// File: rtl/core_cycle_fsm.sv
module core_cycle_fsm
  import core_cycle_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           rdInit,
  input  logic           wrInit,
  input  logic [1:0]     modeSel,
  input  logic           fullCycSel,
  input  logic           rdOnlyEn,
  output dpCtl_t         ctl,
  output phase_t         phase,
  output logic           busy
);

  logic     rdPrev, wrPrev;
  logic     rdRise, wrRise, startReq;
  phase_t   phaseNext;
  cycMode_t cycMode, effMode;

  assign rdRise   = rdInit & ~rdPrev;
  assign wrRise   = wrInit & ~wrPrev;
  assign startReq = rdRise | wrRise;

  // qualifier inputs fold unsupported variants into read/restore
  always_comb begin
    effMode = cycMode_t'(modeSel);
    if (effMode == MODE_RD_MOD && fullCycSel) effMode = MODE_RD_RST;
    if (effMode == MODE_RD_ONLY && !rdOnlyEn) effMode = MODE_RD_RST;
  end

  always_comb begin
    ctl       = '0;
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (startReq) begin
          ctl.latchCyc = 1'b1;
          phaseNext    = (effMode == MODE_CLR_WR) ? PH_CLR : PH_READ;
        end
      end
      PH_CLR: begin
        ctl.clrWord = 1'b1;
        phaseNext   = PH_WRITE;
      end
      PH_READ: begin
        ctl.rdWord = 1'b1;
        unique case (cycMode)
          MODE_RD_MOD:  phaseNext = PH_PAUSE;
          MODE_RD_ONLY: phaseNext = PH_IDLE;
          default:      phaseNext = PH_RESTORE;
        endcase
      end
      PH_PAUSE: begin
        if (wrRise) begin
          ctl.latchWr = 1'b1;
          phaseNext   = PH_WRITE;
        end
      end
      PH_WRITE: begin
        ctl.wrWord = 1'b1;
        phaseNext  = PH_IDLE;
      end
      PH_RESTORE: begin
        ctl.rstWord = 1'b1;
        phaseNext   = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cycMode <= MODE_CLR_WR;
      rdPrev  <= 1'b0;
      wrPrev  <= 1'b0;
    end else begin
      phase  <= phaseNext;
      rdPrev <= rdInit;
      wrPrev <= wrInit;
      if (phase == PH_IDLE && startReq) cycMode <= effMode;
    end
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/core_cycle_dp.sv
module core_cycle_dp
  import core_cycle_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic [AW-1:0] cycAddr
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] cycData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycAddr <= '0;
      cycData <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.rdWord;
      if (ctl.latchCyc) begin
        cycAddr <= addr;
        cycData <= wrData;
      end
      if (ctl.latchWr) cycData <= wrData;
      if (ctl.rdWord)  rdData  <= mem[cycAddr];
    end
  end

  // one register per word; only the addressed one responds
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic sel;
    assign sel = (cycAddr == AW'(w));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                mem[w] <= '0;
      else if (sel && (ctl.clrWord || ctl.rdWord)) mem[w] <= '0;
      else if (sel && ctl.wrWord)               mem[w] <= cycData;
      else if (sel && ctl.rstWord)              mem[w] <= rdData;
    end
  end

endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl
  import core_cycle_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdInit,
  input  logic          wrInit,
  input  logic [1:0]    modeSel,
  input  logic          fullCycSel,
  input  logic          rdOnlyEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic          busy
);

  dpCtl_t        ctlW;
  phase_t        phaseW;
  logic [AW-1:0] cycAddrW;

  core_cycle_fsm u_fsm (
    .clk(clk), .rstN(rstN), .rdInit(rdInit), .wrInit(wrInit),
    .modeSel(modeSel), .fullCycSel(fullCycSel), .rdOnlyEn(rdOnlyEn),
    .ctl(ctlW), .phase(phaseW), .busy(busy)
  );

  core_cycle_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlW), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .cycAddr(cycAddrW)
  );

endmodule

// File: rtl/core_cycle_chk.sv
module core_cycle_chk
  import core_cycle_pkg::*;
#(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdInit,
  input logic          wrInit,
  input logic          busy,
  input logic          rdValid,
  input logic [2:0]    phase,
  input logic [AW-1:0] cycAddr
);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !busy && ((rdInit && !$past(rdInit)) || (wrInit && !$past(wrInit)))) |=> busy);

  // R4
  rdvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R4
  rdvalid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && rdValid) |-> ($past(phase) == PH_READ));

  // R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && phase == PH_PAUSE && !(wrInit && !$past(wrInit))) |=> (phase == PH_PAUSE && busy));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && busy && $past(busy)) |-> $stable(cycAddr));

endmodule

bind core_cycle_ctrl core_cycle_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .rdInit(rdInit), .wrInit(wrInit),
  .busy(busy), .rdValid(rdValid), .phase(phaseW), .cycAddr(cycAddrW)
);

// File: tb/core_cycle_ctrl_bench.sv
module core_cycle_ctrl_bench;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NV = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic rdInit = 1'b0, wrInit = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic fullCycSel = 1'b0, rdOnlyEn = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic rdValid, busy;

  int nChk = 0, nFail = 0;
  int rvCount;
  logic [DW-1:0] rvData;

  always #4 clk = ~clk;

  core_cycle_ctrl #(.AW(AW), .DW(DW)) u_core_cycle_ctrl (
    .clk(clk), .rstN(rstN), .rdInit(rdInit), .wrInit(wrInit),
    .modeSel(modeSel), .fullCycSel(fullCycSel), .rdOnlyEn(rdOnlyEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .busy(busy)
  );

  // {mode, addr, wrData, expect rdValid, expected rdData}
  localparam logic [22:0] VEC [NV] = '{
    {2'b00, 4'd3, 8'hA5, 1'b0, 8'h00},
    {2'b01, 4'd3, 8'h00, 1'b1, 8'hA5},
    {2'b01, 4'd3, 8'h00, 1'b1, 8'hA5},
    {2'b00, 4'd7, 8'h3C, 1'b0, 8'h00},
    {2'b11, 4'd7, 8'h00, 1'b1, 8'h3C},
    {2'b01, 4'd7, 8'h00, 1'b1, 8'h00},
    {2'b00, 4'd3, 8'h5A, 1'b0, 8'h00},
    {2'b01, 4'd3, 8'h00, 1'b1, 8'h5A}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // starts a cycle on one init line and runs until busy drops
  task automatic runCycle(input logic useWr, input logic [1:0] m,
                          input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic holdHigh);
    rvCount = 0;
    rvData  = '0;
    @(negedge clk);
    modeSel = m; addr = a; wrData = d;
    if (useWr) wrInit = 1'b1; else rdInit = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!holdHigh) begin rdInit = 1'b0; wrInit = 1'b0; end
      if (rdValid) begin rvCount++; rvData = rdData; end
      if (!busy) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(rdValid == 1'b0, "R1 rdValid", rdValid, 0);
    check(rdData == '0, "R1 rdData", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    runCycle(1'b0, 2'b01, 4'd12, 8'h00, 1'b0);
    check(rvCount == 1 && rvData == 8'h00, "R1 array zero", rvData, 0);

    // table: R3 clear/write, R4 read/restore, R5 read-only
    for (int v = 0; v < NV; v++) begin
      runCycle(v[0], VEC[v][22:21], VEC[v][20:17], VEC[v][16:9], 1'b0);
      check(rvCount == (VEC[v][8] ? 1 : 0), "R3/R4/R5 rdValid count", rvCount, VEC[v][8]);
      if (VEC[v][8])
        check(rvData == VEC[v][7:0], "R4/R5 rdData", rvData, VEC[v][7:0]);
    end

    // R2: busy after start edge on wrInit
    @(negedge clk);
    modeSel = 2'b01; addr = 4'd3; wrInit = 1'b1;
    @(negedge clk);
    wrInit = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R2 idle after cycle", busy, 0);

    // R6 split cycle, R7 stray rdInit during pause
    @(negedge clk);
    modeSel = 2'b10; addr = 4'd3; wrData = 8'hEE; rdInit = 1'b1;
    @(negedge clk);
    rdInit = 1'b0;
    @(negedge clk);
    check(rdValid == 1'b1 && rdData == 8'h5A, "R6 split read data", rdData, 8'h5A);
    addr = 4'd9;
    repeat (10) @(negedge clk);
    check(busy == 1'b1, "R6 busy in pause", busy, 1);
    rdInit = 1'b1;
    @(negedge clk);
    rdInit = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b1 && rdValid == 1'b0, "R7 stray rdInit ignored", busy, 1);
    wrData = 8'h77; wrInit = 1'b1;
    @(negedge clk);
    wrInit = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R6 pause released", busy, 0);
    runCycle(1'b0, 2'b01, 4'd3, 8'h00, 1'b0);
    check(rvData == 8'h77, "R6 modified word stored", rvData, 8'h77);
    runCycle(1'b0, 2'b01, 4'd9, 8'h00, 1'b0);
    check(rvData == 8'h00, "R7 address held", rvData, 0);

    // R8: forced full cycle
    fullCycSel = 1'b1;
    runCycle(1'b0, 2'b10, 4'd3, 8'h11, 1'b0);
    check(busy == 1'b0 && rvData == 8'h77, "R8 no pause", rvData, 8'h77);
    fullCycSel = 1'b0;
    runCycle(1'b0, 2'b01, 4'd3, 8'h00, 1'b0);
    check(rvData == 8'h77, "R8 word restored", rvData, 8'h77);

    // R9: read-only disabled
    rdOnlyEn = 1'b0;
    runCycle(1'b0, 2'b11, 4'd3, 8'h00, 1'b0);
    rdOnlyEn = 1'b1;
    runCycle(1'b0, 2'b01, 4'd3, 8'h00, 1'b0);
    check(rvData == 8'h77, "R9 word kept", rvData, 8'h77);

    // R10: held-high init does not retrigger
    runCycle(1'b0, 2'b01, 4'd3, 8'h00, 1'b1);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R10 no retrigger", busy, 0);
    rdInit = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule